// File: doc/BRIEF.md
# Two-Road Crossing Lamp Controller

This block sequences the lamps at a crossing of a main road (A) and a side road (B). Each road has a vehicle-presence input, and each road has a red, a yellow and a green lamp output. The main road holds green by default. It hands over to the side road only after its minimum green time has passed and a side-road vehicle is present. The side road gets one minimum green interval. It keeps green for a further full interval only when it still has traffic and the main road has none.

All timing is counted in ticks of a one-cycle enable input, `tick_en`, which a system normally pulses once per second. The minimum green interval and the yellow interval are parameters (defaults 50 and 5 ticks), so a test can shorten them. The phases always run in the same order: A green, A yellow, B green, B yellow, then A green again. A synchronous active-low reset places the block in A green with its interval timer cleared.

Top module: `traffic_xing_ctrl`

## Requirements
- R1: After reset the outputs are A green and B red, which is lamp word {a_red,a_yel,a_grn,b_red,b_yel,b_grn} = 6'b001100. The interval timer starts from zero, so a full minimum green interval must pass before A can leave green.
- R2: Each road has exactly one lamp lit at all times. Whenever one road shows green or yellow, the other road shows red.
- R3: While fewer than MIN_GREEN_TICKS ticks have occurred since A entered green, A stays green whatever the sensors show.
- R4: Once the A minimum has elapsed, A stays green for as long as `car_b` is 0. On the first clock that `car_b` is 1, A goes to yellow (6'b010100) at the next edge.
- R5: A yellow phase lasts YELLOW_TICKS ticks. It then gives way to the other road's green: A yellow leads to B green (6'b100001), and B yellow leads to A green (6'b001100).
- R6: At the end of a B green interval of MIN_GREEN_TICKS ticks, B goes to yellow (6'b100010) unless `car_b` is 1 and `car_a` is 0.
- R7: If `car_b` is 1 and `car_a` is 0 at the end of a B green interval, B stays green and a new full interval of MIN_GREEN_TICKS ticks begins.
- R8: With `tick_en` held at 0, timing does not advance. A phase whose interval has not yet elapsed is held for any number of clocks.
- R9: Phases change only in the order A green, A yellow, B green, B yellow, A green.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_en | input | 1 | One-cycle timing tick (one second in normal use) |
| car_a | input | 1 | Vehicle present on main road A |
| car_b | input | 1 | Vehicle present on side road B |
| a_red | output | 1 | Road A red lamp |
| a_yel | output | 1 | Road A yellow lamp |
| a_grn | output | 1 | Road A green lamp |
| b_red | output | 1 | Road B red lamp |
| b_yel | output | 1 | Road B yellow lamp |
| b_grn | output | 1 | Road B green lamp |

## Verification
The assertions take `tick_en` to be a one-cycle pulse. They also take the sensors to be synchronous to `clk`, because the controller acts on them in the clock that they are sampled. The checker counts ticks itself during A green so that it can bound the main-road minimum.

The stimulus always raises the tick for a single cycle and then keeps it low for at least one cycle, so every phase change has settled before the lamps are sampled. The sensors change only at falling clock edges and stay steady across each tick.

// File: rtl/xing_pkg.sv
// Package: shared phase type and lamp decode for the crossing controller.
// Assumes two roads, indexed 0 (main, A) and 1 (side, B).
package xing_pkg;

    typedef enum logic [1:0] {
        PH_A_GRN = 2'd0,
        PH_A_YEL = 2'd1,
        PH_B_GRN = 2'd2,
        PH_B_YEL = 2'd3
    } phase_t;

    // Lamp set for one road, ordered red, yellow, green.
    typedef struct packed {
        logic red;
        logic yel;
        logic grn;
    } lamps_t;

    // Lamps of road `road` during phase `ph`: green or yellow when it owns the phase, red otherwise.
    function automatic lamps_t road_lamps(input phase_t ph, input int road);
        lamps_t l;
        phase_t own_grn;
        phase_t own_yel;
        own_grn = (road == 0) ? PH_A_GRN : PH_B_GRN;
        own_yel = (road == 0) ? PH_A_YEL : PH_B_YEL;
        l.grn = (ph == own_grn);
        l.yel = (ph == own_yel);
        l.red = !(l.grn || l.yel);
        return l;
    endfunction

endpackage

// File: rtl/xing_timer.sv
// Module: xing_timer
// Counts timing ticks since the last restart and saturates at CAP.
// Assumes restart and tick are synchronous; restart takes priority over tick.
module xing_timer #(
    parameter int CAP   = 50,
    localparam int CW   = $clog2(CAP + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          restart,
    output logic [CW-1:0] count
);

    // Tick counter: clears on reset or restart, otherwise counts ticks up to CAP.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            count <= '0;
        end else if (tick && (count < CW'(CAP))) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/xing_fsm.sv
// Module: xing_fsm
// Holds the crossing phase and chooses the next one from the timer and the sensors.
// Assumes count is the number of ticks since the phase (or extension) began.
// Raises restart whenever the phase changes or the side-road green is extended.
module xing_fsm
    import xing_pkg::*;
#(
    parameter int MIN_GREEN_TICKS = 50,
    parameter int YELLOW_TICKS    = 5,
    parameter int CW              = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] count,
    input  logic          car_a,
    input  logic          car_b,
    output phase_t        phase,
    output logic          restart
);

    phase_t next_phase;
    logic   green_done;
    logic   yellow_done;
    logic   extend;

    // Interval-elapsed flags compared against the timer.
    always_comb begin
        green_done  = (count >= CW'(MIN_GREEN_TICKS));
        yellow_done = (count >= CW'(YELLOW_TICKS));
    end

    // Next-phase selection: main-road priority with side-road extension.
    always_comb begin
        next_phase = phase;
        extend     = 1'b0;
        case (phase)
            PH_A_GRN: if (green_done && car_b) next_phase = PH_A_YEL;
            PH_A_YEL: if (yellow_done)         next_phase = PH_B_GRN;
            PH_B_GRN: begin
                if (green_done) begin
                    if (car_b && !car_a) extend     = 1'b1;
                    else                 next_phase = PH_B_YEL;
                end
            end
            PH_B_YEL: if (yellow_done)         next_phase = PH_A_GRN;
            default:                           next_phase = PH_A_GRN;
        endcase
    end

    // Timer restart request on any phase change or extension.
    always_comb begin
        restart = (next_phase != phase) || extend;
    end

    // Phase register with synchronous active-low reset into main-road green.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_A_GRN;
        else        phase <= next_phase;
    end

endmodule

// File: rtl/xing_lamp_dec.sv
// Module: xing_lamp_dec
// Decodes the phase into per-road lamp sets, one generated decoder per road.
// Assumes index 0 is road A and index 1 is road B.
module xing_lamp_dec
    import xing_pkg::*;
#(
    parameter int ROADS = 2
) (
    input  phase_t phase,
    output lamps_t lamps [ROADS]
);

    for (genvar r = 0; r < ROADS; r++) begin : g_road
        // Per-road lamp decode.
        always_comb begin
            lamps[r] = road_lamps(phase, r);
        end
    end

endmodule

// File: rtl/traffic_xing_ctrl.sv
// Module: traffic_xing_ctrl (top)
// Two-road crossing controller: main road A has priority and side road B is served on demand.
// Assumes tick_en is a one-cycle pulse and the sensors are synchronous to clk.
module traffic_xing_ctrl
    import xing_pkg::*;
#(
    parameter int MIN_GREEN_TICKS = 50,
    parameter int YELLOW_TICKS    = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic car_a,
    input  logic car_b,
    output logic a_red,
    output logic a_yel,
    output logic a_grn,
    output logic b_red,
    output logic b_yel,
    output logic b_grn
);

    localparam int CAP = (MIN_GREEN_TICKS > YELLOW_TICKS) ? MIN_GREEN_TICKS : YELLOW_TICKS;
    localparam int CW  = $clog2(CAP + 1);

    logic [CW-1:0] count;
    logic          restart;
    phase_t        phase;
    lamps_t        lamps [2];

    xing_timer #(.CAP(CAP)) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_en),
        .restart (restart),
        .count   (count)
    );

    xing_fsm #(
        .MIN_GREEN_TICKS (MIN_GREEN_TICKS),
        .YELLOW_TICKS    (YELLOW_TICKS),
        .CW              (CW)
    ) fsm_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .count   (count),
        .car_a   (car_a),
        .car_b   (car_b),
        .phase   (phase),
        .restart (restart)
    );

    xing_lamp_dec #(.ROADS(2)) dec_i (
        .phase (phase),
        .lamps (lamps)
    );

    // Lamp outputs taken from the per-road decoders.
    always_comb begin
        {a_red, a_yel, a_grn} = lamps[0];
        {b_red, b_yel, b_grn} = lamps[1];
    end

endmodule

// File: rtl/xing_ctrl_chk.sv
// Module: xing_ctrl_chk
// Port-level checker for the crossing controller, bound to the top module.
// Keeps its own count of ticks during main-road green to bound the minimum.
module xing_ctrl_chk #(
    parameter int MIN_GREEN_TICKS = 50,
    localparam int CW = $clog2(MIN_GREEN_TICKS + 1)
) (
    input logic clk,
    input logic rst_n,
    input logic tick_en,
    input logic car_a,
    input logic car_b,
    input logic a_red,
    input logic a_yel,
    input logic a_grn,
    input logic b_red,
    input logic b_yel,
    input logic b_grn
);

    logic [CW-1:0] a_ticks;

    // Ticks seen since road A turned green, saturating at the minimum.
    always_ff @(posedge clk) begin
        if (!rst_n || !a_grn) a_ticks <= '0;
        else if (tick_en && (a_ticks < CW'(MIN_GREEN_TICKS))) a_ticks <= a_ticks + 1'b1;
    end

    AST_ONE_LAMP_A: assert property (@(posedge clk) disable iff (!rst_n) $countones({a_red, a_yel, a_grn}) == 1); // R2
    AST_ONE_LAMP_B: assert property (@(posedge clk) disable iff (!rst_n) $countones({b_red, b_yel, b_grn}) == 1); // R2
    AST_CROSS_RED_B: assert property (@(posedge clk) disable iff (!rst_n) (a_grn || a_yel) |-> b_red); // R2
    AST_CROSS_RED_A: assert property (@(posedge clk) disable iff (!rst_n) (b_grn || b_yel) |-> a_red); // R2
    AST_A_MIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (a_grn && (a_ticks < CW'(MIN_GREEN_TICKS))) |=> a_grn); // R3
    AST_A_NO_CAR_B: assert property (@(posedge clk) disable iff (!rst_n) (a_grn && !car_b) |=> a_grn); // R4
    AST_B_EXTEND: assert property (@(posedge clk) disable iff (!rst_n) (b_grn && car_b && !car_a) |=> b_grn); // R7
    AST_ORDER_AG: assert property (@(posedge clk) disable iff (!rst_n) a_grn |=> (a_grn || a_yel)); // R9
    AST_ORDER_AY: assert property (@(posedge clk) disable iff (!rst_n) a_yel |=> (a_yel || b_grn)); // R9
    AST_ORDER_BG: assert property (@(posedge clk) disable iff (!rst_n) b_grn |=> (b_grn || b_yel)); // R9
    AST_ORDER_BY: assert property (@(posedge clk) disable iff (!rst_n) b_yel |=> (b_yel || a_grn)); // R9

endmodule

bind traffic_xing_ctrl xing_ctrl_chk #(.MIN_GREEN_TICKS(MIN_GREEN_TICKS)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .car_a   (car_a),
    .car_b   (car_b),
    .a_red   (a_red),
    .a_yel   (a_yel),
    .a_grn   (a_grn),
    .b_red   (b_red),
    .b_yel   (b_yel),
    .b_grn   (b_grn)
);

// File: tb/traffic_xing_ctrl_tb_top.sv
// Directed bench for the crossing controller, with short timing parameters.
module traffic_xing_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int MIN_G      = 4;
    localparam int YEL        = 2;

    localparam logic [5:0] L_AG = 6'b001100;
    localparam logic [5:0] L_AY = 6'b010100;
    localparam logic [5:0] L_BG = 6'b100001;
    localparam logic [5:0] L_BY = 6'b100010;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_en = 1'b0;
    logic car_a = 1'b0;
    logic car_b = 1'b0;
    logic a_red, a_yel, a_grn, b_red, b_yel, b_grn;

    int checks = 0;
    int errors = 0;

    traffic_xing_ctrl #(.MIN_GREEN_TICKS(MIN_G), .YELLOW_TICKS(YEL)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .car_a(car_a), .car_b(car_b),
        .a_red(a_red), .a_yel(a_yel), .a_grn(a_grn),
        .b_red(b_red), .b_yel(b_yel), .b_grn(b_grn)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [5:0] lamps();
        return {a_red, a_yel, a_grn, b_red, b_yel, b_grn};
    endfunction

    task automatic check(input string tag, input logic [5:0] exp);
        checks++;
        if (lamps() !== exp) begin
            errors++;
            $display("FAIL %s: lamps actual %b expected %b", tag, lamps(), exp);
        end
    endtask

    // Reset held for three clocks, released at a falling edge.
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; tick_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Each tick: one cycle high, one cycle low; returns at a falling edge.
    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick_en = 1'b1;
            @(negedge clk);
            tick_en = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Drive from reset to B green: A minimum, request, then A yellow.
    task automatic to_b_green();
        do_reset();
        car_a = 1'b0; car_b = 1'b1;
        ticks(MIN_G);
        ticks(YEL);
    endtask

    task automatic t_reset();
        car_a = 1'b1; car_b = 1'b1;
        do_reset();
        check("R1 reset lamps", L_AG);
        ticks(MIN_G - 1);
        check("R1 timer cleared at reset, A still green", L_AG);
    endtask

    task automatic t_a_min();
        car_a = 1'b0; car_b = 1'b1;
        do_reset();
        ticks(MIN_G - 1);
        check("R3 A green before minimum with car_b", L_AG);
        idle(20);
        check("R8 no tick, A held", L_AG);
        ticks(1);
        check("R4 A yellow after minimum with car_b", L_AY);
    endtask

    task automatic t_a_hold();
        car_a = 1'b1; car_b = 1'b0;
        do_reset();
        ticks(MIN_G + 3);
        check("R4 A stays green, no car_b", L_AG);
        car_b = 1'b1;
        @(negedge clk);
        check("R4 A yellow one edge after car_b", L_AY);
    endtask

    task automatic t_yellow();
        car_a = 1'b0; car_b = 1'b1;
        do_reset();
        ticks(MIN_G);
        ticks(YEL - 1);
        check("R5 A yellow held before interval", L_AY);
        idle(10);
        check("R8 no tick, yellow held", L_AY);
        ticks(1);
        check("R5 A yellow to B green", L_BG);
    endtask

    task automatic t_b_end();
        to_b_green();
        car_a = 1'b1; car_b = 1'b1;
        ticks(MIN_G - 1);
        check("R6 B green before its interval ends", L_BG);
        ticks(1);
        check("R6 B yellow, car_a present", L_BY);
        ticks(YEL - 1);
        check("R5 B yellow held", L_BY);
        ticks(1);
        check("R9 B yellow to A green", L_AG);
    endtask

    task automatic t_b_empty();
        to_b_green();
        car_a = 1'b0; car_b = 1'b0;
        ticks(MIN_G);
        check("R6 B yellow, no traffic", L_BY);
    endtask

    task automatic t_extend();
        to_b_green();
        car_a = 1'b0; car_b = 1'b1;
        ticks(MIN_G);
        check("R7 B extended at interval end", L_BG);
        car_a = 1'b1;
        ticks(MIN_G - 1);
        check("R7 extension is a full new interval", L_BG);
        ticks(1);
        check("R6 B yellow after extension", L_BY);
    endtask

    // Watchdog: a hung run is one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_a_min();
        t_a_hold();
        t_yellow();
        t_b_end();
        t_b_empty();
        t_extend();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule